// File: doc/BRIEF.md
# Retention-Aware Multi-Rate Refresh Scheduler

This block sits inside a DRAM memory controller and decides which rows receive a refresh, and when. It does not refresh every row at one fixed interval. Instead, each row is assigned one of three refresh periods according to its retention class. Rows that hold weak cells get the shortest period, and all other rows get a longer one. Class membership is held in two small Bloom filters: a fast filter and a medium filter. An earlier profiling pass produces the retention data, and configuration writes then load it into the filters bit by bit.

A tick counter divides the base 64 ms window into one slot per row. On each slot the scheduler visits the next row in ascending order. It looks the row up in both filters and uses a 2-bit window counter to decide whether the row is due. If the row is due, it raises a refresh request toward the command scheduler and holds that request until the command scheduler accepts it. While a request is waiting, the row walk pauses, so no row is skipped.

Top module: `retention_refresh_sched`

## Requirements
- R1: A row that is a member of the fast filter (filter select 0) is requested in every window, that is, once per 64 ms base period.
- R2: A row that is a member of the medium filter (filter select 1) but not of the fast filter is requested only in windows whose 2-bit window number is even (0 or 2), that is, once per 128 ms.
- R3: A row that is in neither filter is requested only in window number 0, that is, once per 256 ms.
- R4: A row is a member of a filter only when both hashed bits of that filter are set. The two hashes are the row address XOR-folded into IDX_W bits: bit i of the address goes to position i mod IDX_W for hash A, and bit ROW_W-1-i goes to that position for hash B. A configuration write with cfg_we high sets bit cfg_idx of filter cfg_sel to cfg_val, and every lookup after that clock edge sees the new value.
- R5: When the walk is not stalled, one row is visited every TICK_CYCLES cycles. Rows are visited in ascending order from 0. When the walk wraps from the last row back to row 0, the window number increments modulo 4. After reset, row 0 of window 0 is visited on the TICK_CYCLES-th rising edge, and a request for it appears just after that edge.
- R6: Once rq_valid is high, it stays high with rq_row unchanged until a cycle in which rq_ready is high. It falls on the following edge.
- R7: While a request is pending, the tick counter holds at its last count and no row is visited. The next visit happens on the edge after the one that accepts the request.
- R8: Synchronous active-low reset clears both filters, the row and window position, and rq_valid.
- R9: A row that is a member of both filters is treated as a fast-filter row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Filter bit write strobe |
| cfg_sel | input | 1 | Filter select: 0 fast, 1 medium |
| cfg_idx | input | IDX_W | Bit position within the selected filter |
| cfg_val | input | 1 | Value written to that bit |
| rq_valid | output | 1 | Refresh request pending |
| rq_row | output | ROW_W | Row address of the pending request |
| rq_ready | input | 1 | Command scheduler accepts the request |

## Verification
The bench runs four full windows from reset and counts the accepted requests for every row. A design that mixed up the window parity or the bin priority would refresh some row 1, 2 or 4 times when it should have used a different count. Rows that hit only one hash bit are checked as well: a design that counted them as members would over-refresh them. Random and long back-pressure on rq_ready is aimed at the stall. A walk that kept advancing under a pending request would drop rows, and the per-cycle comparison would catch it. Filter bits are also cleared and rewritten while the walk is running, to expose a lookup that sees a stale value or a value one cycle early.

// File: rtl/rrs_pkg.sv
// Shared types for the retention-aware refresh scheduler.
// Assumes three refresh classes and a 2-bit window counter (four base windows).
package rrs_pkg;
    localparam int WIN_W     = 2;
    localparam int NUM_FILT  = 2;

    typedef enum logic [1:0] {
        BIN_FAST = 2'd0,
        BIN_MID  = 2'd1,
        BIN_SLOW = 2'd2
    } bin_e;

    // Picks the refresh class from filter hits; the fast filter wins.
    function automatic bin_e pick_bin(input logic hit_fast, input logic hit_mid);
        if (hit_fast)     return BIN_FAST;
        else if (hit_mid) return BIN_MID;
        else              return BIN_SLOW;
    endfunction

    // Decides whether a class is due in a given window number.
    function automatic logic bin_due(input bin_e b, input logic [WIN_W-1:0] win);
        case (b)
            BIN_FAST: return 1'b1;
            BIN_MID:  return ~win[0];
            default:  return (win == '0);
        endcase
    endfunction
endpackage

// File: rtl/rrs_bloom.sv
// One Bloom filter of 2**IDX_W bits with two XOR-fold hashes of the row.
// A row hits only when both hashed bits are set. Bits are written one at a
// time; the write is seen by lookups after the clock edge that performs it.
module rrs_bloom #(
    parameter int ROW_W = 6,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_val,
    input  logic [ROW_W-1:0] row,
    output logic             hit
);
    localparam int BITS = 1 << IDX_W;

    logic [BITS-1:0]  vec;
    logic [IDX_W-1:0] ha;
    logic [IDX_W-1:0] hb;

    // Filter bit storage: cleared on reset, single-bit writes.
    always_ff @(posedge clk) begin
        if (!rst_n)     vec <= '0;
        else if (wr_en) vec[wr_idx] <= wr_val;
    end

    // Two folds of the row address: straight order and reversed order.
    always_comb begin
        ha = '0;
        hb = '0;
        for (int i = 0; i < ROW_W; i++) begin
            ha[i % IDX_W] = ha[i % IDX_W] ^ row[i];
            hb[i % IDX_W] = hb[i % IDX_W] ^ row[ROW_W-1-i];
        end
    end

    // Membership needs both indexed bits set.
    assign hit = vec[ha] & vec[hb];

    p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vec[$past(wr_idx)] == $past(wr_val));
endmodule

// File: rtl/rrs_timebase.sv
// Slot timer and row/window walker. One slot lasts TICK_CYCLES cycles; on the
// last cycle of a slot the current row is visited unless a request is pending,
// in which case the counter holds until the pending request is accepted.
module rrs_timebase #(
    parameter int ROW_W       = 6,
    parameter int TICK_CYCLES = 8,
    parameter int WIN_W       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pend,
    output logic             visit,
    output logic [ROW_W-1:0] row,
    output logic [WIN_W-1:0] win
);
    localparam int CNT_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_CYCLES - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = '1;

    logic [CNT_W-1:0] cnt;
    logic             at_last;

    assign at_last = (cnt == CNT_LAST);
    assign visit   = at_last & ~pend;

    // Slot counter: counts up, holds at the last count while stalled.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (visit)   cnt <= '0;
        else if (!at_last) cnt <= cnt + 1'b1;
    end

    // Row walker: advance on each visit, bump the window on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row <= '0;
            win <= '0;
        end else if (visit) begin
            row <= row + 1'b1;
            if (row == ROW_LAST) win <= win + 1'b1;
        end
    end

    p_stall_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && at_last) |=> (cnt == CNT_LAST) && $stable(row) && $stable(win));

    p_wrap_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (visit && row == ROW_LAST) |=> (row == '0) && (win == WIN_W'($past(win) + 1'b1)));

    p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_LAST);
endmodule

// File: rtl/rrs_issue.sv
// Refresh decision and request register. On a visit, the filter hits pick a
// class, the window number says if that class is due, and a due row is
// latched as a request held until the command side accepts it.
module rrs_issue
    import rrs_pkg::*;
#(
    parameter int ROW_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             visit,
    input  logic [ROW_W-1:0] row,
    input  logic [WIN_W-1:0] win,
    input  logic             hit_fast,
    input  logic             hit_mid,
    input  logic             rq_ready,
    output logic             rq_valid,
    output logic [ROW_W-1:0] rq_row
);
    bin_e cls;
    logic due;

    // Class lookup and due decision for the visited row.
    always_comb begin
        cls = pick_bin(hit_fast, hit_mid);
        due = bin_due(cls, win);
    end

    // Request register: set on a due visit, cleared on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_valid <= 1'b0;
            rq_row   <= '0;
        end else if (visit && due) begin
            rq_valid <= 1'b1;
            rq_row   <= row;
        end else if (rq_valid && rq_ready) begin
            rq_valid <= 1'b0;
        end
    end

    p_hold_until_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_valid && !rq_ready) |=> rq_valid && $stable(rq_row));

    p_fast_every_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (visit && hit_fast) |=> rq_valid && (rq_row == $past(row)));

    p_slow_only_w0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (visit && !hit_fast && !hit_mid && win != '0) |=> !rq_valid);

    p_reset_clears_r8: assert property (@(posedge clk)
        !rst_n |=> !rq_valid);
endmodule

// File: rtl/retention_refresh_sched.sv
// Top of the retention-aware refresh scheduler: two Bloom filters (fast and
// medium class), the slot/row walker, and the request issue stage.
// Assumes profiling has already produced the filter contents.
module retention_refresh_sched
    import rrs_pkg::*;
#(
    parameter int ROW_W       = 6,
    parameter int IDX_W       = 4,
    parameter int TICK_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic             cfg_val,
    output logic             rq_valid,
    output logic [ROW_W-1:0] rq_row,
    input  logic             rq_ready
);
    logic [NUM_FILT-1:0] hits;
    logic                visit;
    logic [ROW_W-1:0]    row;
    logic [WIN_W-1:0]    win;

    // One filter per non-default class; index 0 is the fast class.
    for (genvar g = 0; g < NUM_FILT; g++) begin : g_filt
        rrs_bloom #(.ROW_W(ROW_W), .IDX_W(IDX_W)) i_bloom (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (cfg_we && (cfg_sel == g[0])),
            .wr_idx (cfg_idx),
            .wr_val (cfg_val),
            .row    (row),
            .hit    (hits[g])
        );
    end

    rrs_timebase #(.ROW_W(ROW_W), .TICK_CYCLES(TICK_CYCLES), .WIN_W(WIN_W)) i_timebase (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (rq_valid),
        .visit (visit),
        .row   (row),
        .win   (win)
    );

    rrs_issue #(.ROW_W(ROW_W)) i_issue (
        .clk      (clk),
        .rst_n    (rst_n),
        .visit    (visit),
        .row      (row),
        .win      (win),
        .hit_fast (hits[0]),
        .hit_mid  (hits[1]),
        .rq_ready (rq_ready),
        .rq_valid (rq_valid),
        .rq_row   (rq_row)
    );

    p_mid_odd_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (visit && !hits[0] && hits[1] && win[0]) |=> !rq_valid);
endmodule

// File: tb/test_retention_refresh_sched.sv
// Bench: behavioural reference model updated on each rising edge, compared
// with the design outputs on each falling edge, plus per-row refresh counts
// over four full windows.
module test_retention_refresh_sched;
    localparam int ROW_W = 6;
    localparam int IDX_W = 4;
    localparam int TICK  = 8;
    localparam int ROWS  = 1 << ROW_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic             cfg_sel = 1'b0;
    logic [IDX_W-1:0] cfg_idx = '0;
    logic             cfg_val = 1'b0;
    logic             rq_ready = 1'b1;
    logic             rq_valid;
    logic [ROW_W-1:0] rq_row;

    int n_vec = 0;
    int n_bad = 0;
    int ready_mode = 1;
    logic [7:0] lfsr = 8'h5a;
    int acc [ROWS];

    // reference model state
    int   m_cnt, m_row, m_win, m_rowo;
    bit   m_val;
    bit   m_fb [2][1 << IDX_W];

    always #2 clk = ~clk;

    retention_refresh_sched #(.ROW_W(ROW_W), .IDX_W(IDX_W), .TICK_CYCLES(TICK))
        i_retention_refresh_sched (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_idx(cfg_idx), .cfg_val(cfg_val), .rq_valid(rq_valid),
        .rq_row(rq_row), .rq_ready(rq_ready));

    function automatic int hash_a(input int r);
        int h = 0;
        for (int i = 0; i < ROW_W; i++) h = h ^ (((r >> i) & 1) << (i % IDX_W));
        return h;
    endfunction

    function automatic int hash_b(input int r);
        int h = 0;
        for (int i = 0; i < ROW_W; i++) h = h ^ (((r >> (ROW_W-1-i)) & 1) << (i % IDX_W));
        return h;
    endfunction

    function automatic bit member(input int f, input int r);
        return m_fb[f][hash_a(r)] && m_fb[f][hash_b(r)];
    endfunction

    function automatic bit partial(input int f, input int r);
        return m_fb[f][hash_a(r)] || m_fb[f][hash_b(r)];
    endfunction

    // Reference model: periods 1/2/4 windows, stall while pending.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_row = 0; m_win = 0; m_val = 0; m_rowo = 0;
            for (int f = 0; f < 2; f++)
                for (int b = 0; b < (1 << IDX_W); b++) m_fb[f][b] = 0;
        end else begin
            bit tick;
            bit due;
            tick = (m_cnt == TICK-1) && !m_val;
            if (m_val && rq_ready) m_val = 0;
            if (tick) begin
                if (member(0, m_row))      due = 1;
                else if (member(1, m_row)) due = (m_win % 2) == 0;
                else                       due = (m_win == 0);
                if (due) begin m_val = 1; m_rowo = m_row; end
                m_row = (m_row + 1) % ROWS;
                if (m_row == 0) m_win = (m_win + 1) % 4;
                m_cnt = 0;
            end else if (m_cnt != TICK-1) begin
                m_cnt = m_cnt + 1;
            end
            if (cfg_we) m_fb[cfg_sel][cfg_idx] = cfg_val;
        end
    end

    // One cycle: compare at the falling edge, then drive ready and count accepts.
    task automatic step(input string tag);
        @(negedge clk);
        n_vec++;
        if (rq_valid !== m_val || (m_val && rq_row !== ROW_W'(m_rowo))) begin
            n_bad++;
            $display("FAIL %s: valid/row actual %b/%0d expected %b/%0d",
                     tag, rq_valid, rq_row, m_val, m_rowo);
        end
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (ready_mode)
            0:       rq_ready = 1'b0;
            1:       rq_ready = 1'b1;
            default: rq_ready = lfsr[0] & lfsr[2];
        endcase
        if (rq_valid && rq_ready) acc[rq_row]++;
    endtask

    task automatic wr_bit(input int f, input int idx, input bit v, input string tag);
        cfg_we = 1'b1; cfg_sel = f[0]; cfg_idx = IDX_W'(idx); cfg_val = v;
        step(tag);
        cfg_we = 1'b0;
    endtask

    task automatic add_row(input int f, input int r, input string tag);
        wr_bit(f, hash_a(r), 1'b1, tag);
        wr_bit(f, hash_b(r), 1'b1, tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cfg_we = 1'b0; ready_mode = 1; rq_ready = 1'b1;
        repeat (3) step("R8");
        n_vec++;
        if (rq_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R8: rq_valid in reset actual %b expected 0", rq_valid);
        end
        rst_n = 1'b1;
        for (int r = 0; r < ROWS; r++) acc[r] = 0;
    endtask

    initial begin
        int held;
        bit seen;
        // Phase 1: four full windows, per-row counts (R1 R2 R3 R4 R5 R9)
        do_reset();
        add_row(0, 5, "R9");  add_row(1, 5, "R9");
        add_row(0, 40, "R1");
        add_row(1, 19, "R2"); add_row(1, 33, "R2");
        for (int i = 0; i < 4 * ROWS * TICK + 2 - 10; i++) step("R5");
        for (int r = 0; r < ROWS; r++) begin
            int exp_n;
            string tag;
            if (member(0, r) && member(1, r)) begin exp_n = 4; tag = "R9"; end
            else if (member(0, r))           begin exp_n = 4; tag = "R1"; end
            else if (member(1, r))           begin exp_n = 2; tag = "R2"; end
            else if (partial(0, r) || partial(1, r)) begin exp_n = 1; tag = "R4"; end
            else                             begin exp_n = 1; tag = "R3"; end
            n_vec++;
            if (acc[r] != exp_n) begin
                n_bad++;
                $display("FAIL %s: row %0d refresh count actual %0d expected %0d",
                         tag, r, acc[r], exp_n);
            end
        end

        // Phase 2: random back-pressure, then a long hold (R6 R7)
        do_reset();
        add_row(0, 12, "R7"); add_row(1, 50, "R7");
        ready_mode = 2;
        for (int i = 0; i < 1500; i++) step("R7");
        ready_mode = 0;
        seen = 0;
        for (int i = 0; i < 200 && !seen; i++) begin
            step("R6");
            if (rq_valid) seen = 1;
        end
        held = rq_row;
        for (int i = 0; i < 30; i++) begin
            step("R6");
            n_vec++;
            if (rq_valid !== 1'b1 || rq_row !== ROW_W'(held)) begin
                n_bad++;
                $display("FAIL R6: held request actual %b/%0d expected 1/%0d",
                         rq_valid, rq_row, held);
            end
        end
        ready_mode = 1;
        for (int i = 0; i < 100; i++) step("R7");

        // Phase 3: filter rewrites during the walk (R4)
        do_reset();
        for (int k = 0; k < 24; k++) begin
            wr_bit(k % 2, (k * 7) % (1 << IDX_W), (k % 3) != 0, "R4");
            for (int i = 0; i < 60; i++) step("R4");
        end
        for (int i = 0; i < 2 * ROWS * TICK; i++) step("R4");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule